// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block adds two unsigned operands and a carry-in without any clock, producing a sum of the operand width and a carry-out. The operand bits are cut into slices whose widths grow from the least significant end: 2, 2, 3, 4, 5 and so on, with the topmost slice cut short where the width runs out. The bottom slice is a plain ripple adder fed directly by the external carry-in.

Every slice above the bottom one computes its local sum once, with an assumed carry-in of zero. It then forms the carry-in-one answer by adding one to that result with an increment converter instead of a second adder. A select stage, steered by the carry arriving from the slice below, passes on one of the two answers, and the selected carry feeds the next slice. All exclusive-OR functions are built from an OR, an AND and an inverter, in the form (a OR b) AND NOT(a AND b).

The width is a parameter. The default is 16 bits, and 8, 32 and 64 bits are the intended alternatives. The block drops into any datapath that needs a single-cycle adder with shallower carry logic than a full ripple chain.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For every pair of operands and either carry-in value, {cout, sum} equals a + b + cin taken over WIDTH+1 bits.
- R2: The slices are 2, 2, 3, 4, 5, ... bits wide from bit 0 upward, and the top slice is truncated to fit WIDTH. A carry entering at bit 0 travels across every slice boundary, so all-ones plus zero with cin = 1 gives sum = 0 and cout = 1.
- R3: The carry-in-one answer of an upper slice is its carry-zero {carry, sum} value plus one. Bit 0 is inverted, bit i is toggled when all lower bits are 1, and the extra top bit is the carry toggled when all sum bits are 1.
- R4: Raising cin from 0 to 1 with the same operands raises {cout, sum} by exactly one.
- R5: The carry leaving each upper slice is the selected carry. A slice whose carry-zero sum is all ones and whose incoming carry is 1 passes a carry upward: 0x000F + 0x0001 gives 0x0010 at 16 bits.
- R6: Every exclusive-OR gives 1 exactly when its two inputs differ, so alternating patterns 0xAAAA + 0x5555 give 0xFFFF with no carry, and 0x10000 with cin = 1.
- R7: The 8, 32 and 64 bit builds meet R1. At 8 bits this holds for every operand pair and carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach is a slice whose carry-zero sum is all ones while the slice below hands it a carry. Only then does the converter's extra top bit become the carry that moves up, and a fault in the selected-carry path shows up nowhere else. The stimulus builds this case on purpose: all-ones operands with carry-in, operands chosen to fill a slice boundary such as 0x07FF + 1 and 0x000F + 1, and the full 8-bit space. Random vectors at 16, 32 and 64 bits then mix the selects, and alternating-bit patterns exercise the exclusive-OR gates.

// File: rtl/csa_pkg.sv
// Package csa_pkg
// Compile-time helpers that describe how the adder width is cut into
// slices. Slice 0 is 2 bits, slice k (k >= 1) is k+1 bits; the top
// slice is truncated so the slices exactly cover the width.
// Assumes a width of at least 2 bits and at most a few hundred bits.
package csa_pkg;

    localparam int MAX_SLICES = 64;

    // Nominal width of slice k before any truncation.
    function automatic int grp_nom(input int k);
        return (k == 0) ? 2 : k + 1;
    endfunction

    // Least significant bit position of slice k.
    function automatic int grp_lsb(input int k);
        int off;
        off = 0;
        for (int j = 0; j < MAX_SLICES; j++) begin
            if (j < k) off += grp_nom(j);
        end
        return off;
    endfunction

    // Number of slices needed to cover a width of w bits.
    function automatic int grp_count(input int w);
        int off;
        int n;
        off = 0;
        n   = 0;
        for (int j = 0; j < MAX_SLICES; j++) begin
            if (off < w) begin
                off += grp_nom(j);
                n++;
            end
        end
        return n;
    endfunction

    // Actual width of slice k in a w-bit adder (top slice truncated).
    function automatic int grp_width(input int w, input int k);
        int lsb;
        lsb = grp_lsb(k);
        return (lsb + grp_nom(k) > w) ? (w - lsb) : grp_nom(k);
    endfunction

endpackage

// File: rtl/csa_xor4.sv
// Module csa_xor4
// Two-input exclusive-OR built as (a | b) & ~(a & b): one OR, one AND,
// one inverter and a final AND. Purely combinational.
module csa_xor4 (
    input  logic a,
    input  logic b,
    output logic y
);

    logic any_one;
    logic both_one;

    // Gate network of the four-gate exclusive-OR.
    assign any_one  = a | b;
    assign both_one = a & b;
    assign y        = any_one & ~both_one;

    // Output is high exactly when the inputs differ.
    always_comb begin : xor_chk_p
        if (!$isunknown({a, b, y})) begin
            AST_XOR_TRUTH: assert (y == (a != b)); // R6
        end
    end

endmodule

// File: rtl/csa_rca.sv
// Module csa_rca
// W-bit ripple-carry adder. When ZERO_CIN is set, the carry-in is known
// to be zero and bit 0 is a half adder; otherwise every bit is a full
// adder. Assumes W >= 1. Purely combinational.
module csa_rca #(
    parameter int W        = 2,
    parameter bit ZERO_CIN = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:1]   carry;
    logic [W-1:0] half;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Bit-local propagate term a ^ b.
        csa_xor4 u_prop (.a(a[i]), .b(b[i]), .y(half[i]));

        if (i == 0 && ZERO_CIN) begin : g_ha
            // Half adder: no incoming carry on the lowest bit.
            assign sum[i]     = half[i];
            assign carry[i+1] = a[i] & b[i];
        end else if (i == 0) begin : g_fa0
            logic s_b;
            // Full adder on the lowest bit, fed by the external carry.
            csa_xor4 u_sum (.a(half[i]), .b(cin), .y(s_b));
            assign sum[i]     = s_b;
            assign carry[i+1] = (a[i] & b[i]) | (half[i] & cin);
        end else begin : g_fa
            logic s_b;
            // Full adder fed by the ripple carry from the bit below.
            csa_xor4 u_sum (.a(half[i]), .b(carry[i]), .y(s_b));
            assign sum[i]     = s_b;
            assign carry[i+1] = (a[i] & b[i]) | (half[i] & carry[i]);
        end
    end

    assign cout = carry[W];

    // Ripple result matches arithmetic addition; zero-carry build sees 0.
    always_comb begin : rca_chk_p
        if (!$isunknown({a, b, cin, sum, cout})) begin
            AST_RCA_TOTAL: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})); // R1
            AST_RCA_ZERO_TIE: assert (!ZERO_CIN || cin == 1'b0); // R3
        end
    end

endmodule

// File: rtl/csa_bec.sv
// Module csa_bec
// Increment converter: takes a W-bit sum and its carry and returns the
// (W+1)-bit value {c, s} + 1 without an adder. Bit 0 is inverted, each
// higher bit toggles when all lower bits are 1, and the top bit is the
// carry toggled when all W bits are 1. Assumes W >= 1.
module csa_bec #(
    parameter int W = 2
) (
    input  logic [W-1:0] s,
    input  logic         c,
    output logic [W:0]   inc
);

    logic [W:0] run;

    // run[i] is the AND of s[i-1:0]; run[0] is the empty product.
    assign run[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_run
        assign run[i+1] = run[i] & s[i];
    end

    // Lowest bit always flips.
    assign inc[0] = ~s[0];

    for (genvar i = 1; i < W; i++) begin : g_tog
        // Bit toggles when every lower bit is one.
        csa_xor4 u_tog (.a(s[i]), .b(run[i]), .y(inc[i]));
    end

    // Extra top bit: carry toggled by an all-ones sum.
    csa_xor4 u_top (.a(c), .b(run[W]), .y(inc[W]));

    // Converter output is the input plus one over W+1 bits.
    always_comb begin : bec_chk_p
        if (!$isunknown({s, c, inc})) begin
            AST_BEC_PLUS_ONE: assert (inc == ({c, s} + {{W{1'b0}}, 1'b1})); // R3
        end
    end

endmodule

// File: rtl/csa_group.sv
// Module csa_group
// One upper slice of the carry-select adder: a single zero-carry ripple
// adder, an increment converter for the carry-one answer, and a select
// stage steered by the carry from the slice below. The carry leaving
// the slice is the selected one. Assumes W >= 1. Purely combinational.
module csa_group #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W-1:0] z_sum;
    logic         z_cout;
    logic [W:0]   one_res;

    // Carry-zero ripple adder (half adder on the low bit).
    csa_rca #(.W(W), .ZERO_CIN(1'b1)) u_rca (
        .a    (a),
        .b    (b),
        .cin  (1'b0),
        .sum  (z_sum),
        .cout (z_cout)
    );

    // Carry-one answer derived from the carry-zero answer.
    csa_bec #(.W(W)) u_bec (
        .s   (z_sum),
        .c   (z_cout),
        .inc (one_res)
    );

    // Select stage: incoming carry picks the answer and the carry out.
    always_comb begin : sel_p
        if (sel) begin
            {cout, sum} = one_res;
        end else begin
            {cout, sum} = {z_cout, z_sum};
        end
    end

    // Selected slice result equals the slice operands plus the select.
    always_comb begin : grp_chk_p
        if (!$isunknown({a, b, sel, sum, cout})) begin
            AST_GRP_SELECT: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, sel})); // R5
        end
    end

endmodule

// File: rtl/csa_sqrt_adder.sv
// Module csa_sqrt_adder
// Square-root carry-select adder of WIDTH bits. Slice 0 is a ripple
// adder fed by cin; every higher slice is a csa_group whose select is
// the carry leaving the slice below. Slice widths come from csa_pkg.
// Assumes WIDTH >= 2. Purely combinational, no clock or reset.
module csa_sqrt_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int NG = csa_pkg::grp_count(WIDTH);

    logic [NG:0] carry;

    // External carry enters the lowest slice.
    assign carry[0] = cin;

    for (genvar g = 0; g < NG; g++) begin : g_slice
        localparam int LSB = csa_pkg::grp_lsb(g);
        localparam int GW  = csa_pkg::grp_width(WIDTH, g);

        if (g == 0) begin : g_base
            // Lowest slice: plain ripple adder with the real carry-in.
            csa_rca #(.W(GW), .ZERO_CIN(1'b0)) u_base (
                .a    (a[LSB +: GW]),
                .b    (b[LSB +: GW]),
                .cin  (carry[g]),
                .sum  (sum[LSB +: GW]),
                .cout (carry[g+1])
            );
        end else begin : g_upper
            // Upper slice: single adder plus converter and select.
            csa_group #(.W(GW)) u_grp (
                .a    (a[LSB +: GW]),
                .b    (b[LSB +: GW]),
                .sel  (carry[g]),
                .sum  (sum[LSB +: GW]),
                .cout (carry[g+1])
            );
        end
    end

    assign cout = carry[NG];

    // Whole adder equals arithmetic addition over WIDTH+1 bits.
    always_comb begin : top_chk_p
        if (!$isunknown({a, b, cin, sum, cout})) begin
            AST_TOTAL_SUM: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})); // R1
        end
    end

endmodule

// File: tb/csa_sqrt_adder_tb_top.sv
// Bench for csa_sqrt_adder: a vector table at 16 bits, directed corner
// cases, an exhaustive 8-bit sweep and random vectors at 16/32/64 bits.
module csa_sqrt_adder_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // 50 MHz clock, used only to pace the watchdog.
    always #10 clk = ~clk;

    logic [15:0] a16, b16, sum16;
    logic        cin16, cout16;
    logic [7:0]  a8, b8, sum8;
    logic        cin8, cout8;
    logic [31:0] a32, b32, sum32;
    logic        cin32, cout32;
    logic [63:0] a64, b64, sum64;
    logic        cin64, cout64;

    csa_sqrt_adder #(.WIDTH(16)) dut_i (
        .a(a16), .b(b16), .cin(cin16), .sum(sum16), .cout(cout16));
    csa_sqrt_adder #(.WIDTH(8)) dut8_i (
        .a(a8), .b(b8), .cin(cin8), .sum(sum8), .cout(cout8));
    csa_sqrt_adder #(.WIDTH(32)) dut32_i (
        .a(a32), .b(b32), .cin(cin32), .sum(sum32), .cout(cout32));
    csa_sqrt_adder #(.WIDTH(64)) dut64_i (
        .a(a64), .b(b64), .cin(cin64), .sum(sum64), .cout(cout64));

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic [16:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 16'h0000, 1'b0, 17'h00000},  // R1 zero
        '{16'hFFFF, 16'h0000, 1'b1, 17'h10000},  // R2 full ripple
        '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},  // R1 max
        '{16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},  // R1
        '{16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},  // R6 alternating
        '{16'hAAAA, 16'h5555, 1'b1, 17'h10000},  // R6 with carry
        '{16'h000F, 16'h0001, 1'b0, 17'h00010},  // R5 slice all ones
        '{16'h1234, 16'h4321, 1'b0, 17'h05555},  // R1
        '{16'h8000, 16'h8000, 1'b0, 17'h10000},  // R1 top carry
        '{16'h0003, 16'h0001, 1'b0, 17'h00004},  // R3 slice 0 to 1
        '{16'h07FF, 16'h0001, 1'b0, 17'h00800},  // R3 boundary at bit 11
        '{16'hF800, 16'h0800, 1'b0, 17'h10000}   // R2 top slice
    };

    // Compare and count; one FAIL line per mismatch.
    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive 16-bit inputs and check against the behavioural sum.
    task automatic run16(input string req, input logic [15:0] x, input logic [15:0] y, input logic c);
        a16 = x; b16 = y; cin16 = c;
        #5;
        chk(req, 65'({cout16, sum16}), 65'({1'b0, x} + {1'b0, y} + {16'd0, c}));
    endtask

    task automatic run32(input string req, input logic [31:0] x, input logic [31:0] y, input logic c);
        a32 = x; b32 = y; cin32 = c;
        #5;
        chk(req, 65'({cout32, sum32}), 65'({1'b0, x} + {1'b0, y} + {32'd0, c}));
    endtask

    task automatic run64(input string req, input logic [63:0] x, input logic [63:0] y, input logic c);
        a64 = x; b64 = y; cin64 = c;
        #5;
        chk(req, {cout64, sum64}, {1'b0, x} + {1'b0, y} + {64'd0, c});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [16:0] lo, hi;
        rst_n = 1'b0;
        a16 = '0; b16 = '0; cin16 = 1'b0;
        a8  = '0; b8  = '0; cin8  = 1'b0;
        a32 = '0; b32 = '0; cin32 = 1'b0;
        a64 = '0; b64 = '0; cin64 = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        // R1: idle state with zero operands gives zero result.
        chk("R1 reset state 16", 65'({cout16, sum16}), 65'd0);
        chk("R1 reset state 64", {cout64, sum64}, 65'd0);
        rst_n = 1'b1;

        // Table walk at 16 bits.
        for (int i = 0; i < NV; i++) begin
            a16 = VEC[i].a; b16 = VEC[i].b; cin16 = VEC[i].cin;
            #5;
            chk("R1 R2 R3 R5 R6 table", 65'({cout16, sum16}), 65'(VEC[i].exp));
        end

        // R4: carry-in adds exactly one.
        a16 = 16'h3C5A; b16 = 16'h0F0F; cin16 = 1'b0;
        #5; lo = {cout16, sum16};
        cin16 = 1'b1;
        #5; hi = {cout16, sum16};
        chk("R4 carry-in step", 65'(hi), 65'(lo + 17'd1));

        // R2: carry crossing every slice at 16 bits.
        run16("R2 ripple all slices", 16'hFFFF, 16'h0000, 1'b1);
        // R5: slice boundaries with all-ones slice and incoming carry.
        run16("R5 slice 2 boundary", 16'h007F, 16'h0001, 1'b0);
        run16("R5 slice 3 boundary", 16'h0003, 16'h07FC, 1'b1);

        // R7: exhaustive 8-bit build.
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int c = 0; c < 2; c++) begin
                    int e;
                    a8 = x[7:0]; b8 = y[7:0]; cin8 = c[0];
                    #1;
                    e = x + y + c;
                    chk("R7 exhaustive 8-bit", 65'({cout8, sum8}), 65'(e[8:0]));
                end
            end
        end

        // R7: 32 and 64 bit corner cases.
        run32("R7 all ones 32", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        run32("R7 ones with carry 32", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        run32("R6 alternating 32", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        run32("R2 ripple 32", 32'hFFFF_FFFF, 32'h0, 1'b1);
        run64("R7 all ones 64", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run64("R7 ones with carry 64", 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
        run64("R6 alternating 64", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
        run64("R2 ripple 64", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);

        // R1 / R7: random vectors at each wider build.
        for (int k = 0; k < 500; k++) begin
            logic [31:0] r0, r1, r2, r3;
            r0 = $urandom; r1 = $urandom; r2 = $urandom; r3 = $urandom;
            run16("R1 random 16", r0[15:0], r1[15:0], r2[0]);
            run32("R7 random 32", r0, r1, r3[0]);
            run64("R7 random 64", {r0, r2}, {r1, r3}, r3[5]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule